// File: doc/BRIEF.md
# Self-Starting Five-Code Sequence Counter

This block is a 3-bit state register that steps through a fixed cycle of five non-binary codes and presents the current code on its output. The cycle, written with bit 2 on the left, is 000, 010, 011, 101, 110, after which it returns to 000. The other three codes (001, 100, 111) are never entered on purpose. Each one has a defined successor, so the counter returns to the cycle on its own. No power-up value can trap it outside the five legal codes.

A synchronous active-high reset puts the counter at 000. While the count enable is low, the code holds. A test load port can write any 3-bit code, including the unused ones, into the register. This lets a bench or a production test place the counter in a chosen state and watch it recover. Two build-time options are available. One selects how the next-state function is built: as sum-of-products equations or as a per-code lookup. The other can tie the enable permanently high.

Top module: `seqc_counter`

## Requirements
- R1: When `rst_i` is high at a rising clock edge, `code_o` is 000 after that edge.
- R2: With `en_i` high and no load, the code advances 000 → 010 → 011 → 101 → 110 → 000 on successive edges.
- R3: With `en_i` high and no load, unused code 001 is followed by 110.
- R4: With `en_i` high and no load, unused code 100 is followed by 010.
- R5: With `en_i` high and no load, unused code 111 is followed by 100.
- R6: With `en_i` high and no load, any of the eight codes is in the legal set {000, 010, 011, 101, 110} after at most two edges.
- R7: With `en_i` low and no load or reset, `code_o` keeps its value across the edge, whether that value is legal or unused.
- R8: When `tst_load_i` is high and `rst_i` is low at an edge, `code_o` equals `tst_code_i` after that edge, whatever the level of `en_i`.
- R9: Reset takes priority over load: with both `rst_i` and `tst_load_i` high, `code_o` becomes 000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| rst_i | input | 1 | Synchronous reset, active high, forces code 000 |
| en_i | input | 1 | Count enable; low holds the current code |
| tst_load_i | input | 1 | Test load strobe, writes `tst_code_i` into the state |
| tst_code_i | input | 3 | Code written by the test load |
| code_o | output | 3 | Current state code |

## Verification
The bound checker monitors every clock edge. On each edge it checks the reset value, the five legal transitions, the successor of each unused code, the hold under a low enable, and that a load writes its code and overrides the enable. The two-edge recovery bound (R6) and the priority of reset over load appear only in the bench's scenarios. There every one of the eight codes is loaded in turn and followed for two enabled edges, and reset is pulsed while a load is pending.

// File: rtl/seqc_pkg.sv
package seqc_pkg;

   localparam int CODE_W = 3;

   typedef logic [CODE_W-1:0] code_t;

   // legal cycle, in order of visit
   localparam code_t C_S0 = 3'b000;
   localparam code_t C_S1 = 3'b010;
   localparam code_t C_S2 = 3'b011;
   localparam code_t C_S3 = 3'b101;
   localparam code_t C_S4 = 3'b110;

   // codes outside the cycle
   localparam code_t C_U1 = 3'b001;
   localparam code_t C_U4 = 3'b100;
   localparam code_t C_U7 = 3'b111;

   // next-state build variants
   localparam int NXT_EQUATION = 0;
   localparam int NXT_LOOKUP   = 1;

endpackage

// File: rtl/seqc_next.sv
module seqc_next
   import seqc_pkg::*;
#(
   parameter int NEXT_STYLE = NXT_EQUATION
) (
   input  code_t cur_i,
   output code_t nxt_o
);

   if (NEXT_STYLE != NXT_EQUATION && NEXT_STYLE != NXT_LOOKUP) begin : g_bad_style
      $error("seqc_next: NEXT_STYLE must be 0 (equation) or 1 (lookup)");
   end

   if (NEXT_STYLE == NXT_EQUATION) begin : g_equation
      logic hi_b, mid_b, lo_b;
      assign hi_b  = cur_i[2];
      assign mid_b = cur_i[1];
      assign lo_b  = cur_i[0];
      // reduced sum-of-products, unused codes resolved toward the cycle
      assign nxt_o[2] = lo_b;
      assign nxt_o[1] = ~mid_b | (~lo_b & ~hi_b);
      assign nxt_o[0] = mid_b & ~hi_b;
   end else begin : g_lookup
      always_comb begin
         unique case (cur_i)
            C_S0:    nxt_o = C_S1;
            C_S1:    nxt_o = C_S2;
            C_S2:    nxt_o = C_S3;
            C_S3:    nxt_o = C_S4;
            C_S4:    nxt_o = C_S0;
            C_U1:    nxt_o = C_S4;
            C_U4:    nxt_o = C_S1;
            default: nxt_o = C_U4;   // only 111 remains
         endcase
      end
   end

endmodule

// File: rtl/seqc_state.sv
module seqc_state
   import seqc_pkg::*;
#(
   parameter bit HAS_ENABLE = 1'b1
) (
   input  logic  clk_i,
   input  logic  rst_i,
   input  logic  en_i,
   input  logic  load_i,
   input  code_t load_code_i,
   input  code_t nxt_i,
   output code_t q_o
);

   logic  adv;
   code_t q_r;

   if (HAS_ENABLE) begin : g_enable
      assign adv = en_i;
   end else begin : g_free_run
      logic unused_en;
      assign unused_en = en_i;
      assign adv = 1'b1;
   end

   // priority: reset, then load, then advance, else hold
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         q_r <= C_S0;
      end else if (load_i) begin
         q_r <= load_code_i;
      end else if (adv) begin
         q_r <= nxt_i;
      end
   end

   assign q_o = q_r;

endmodule

// File: rtl/seqc_counter.sv
module seqc_counter
   import seqc_pkg::*;
#(
   parameter int STATE_W    = 3,
   parameter int NEXT_STYLE = NXT_EQUATION,
   parameter bit HAS_ENABLE = 1'b1
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               en_i,
   input  logic               tst_load_i,
   input  logic [STATE_W-1:0] tst_code_i,
   output logic [STATE_W-1:0] code_o
);

   if (STATE_W != CODE_W) begin : g_bad_width
      $error("seqc_counter: STATE_W must equal the 3-bit code width");
   end

   code_t cur_code;
   code_t nxt_code;

   seqc_next #(
      .NEXT_STYLE (NEXT_STYLE)
   ) i_next (
      .cur_i (cur_code),
      .nxt_o (nxt_code)
   );

   seqc_state #(
      .HAS_ENABLE (HAS_ENABLE)
   ) i_state (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .en_i        (en_i),
      .load_i      (tst_load_i),
      .load_code_i (code_t'(tst_code_i)),
      .nxt_i       (nxt_code),
      .q_o         (cur_code)
   );

   assign code_o = cur_code;

endmodule

// File: rtl/seqc_counter_chk.sv
module seqc_counter_chk (
   input logic       clk_i,
   input logic       rst_i,
   input logic       en_i,
   input logic       tst_load_i,
   input logic [2:0] tst_code_i,
   input logic [2:0] code_o
);

   logic stepping;
   assign stepping = en_i && !tst_load_i;

   AST_RESET_ZERO: assert property (@(posedge clk_i) rst_i |=> code_o == 3'b000); // R1

   AST_STEP_S0: assert property (@(posedge clk_i) disable iff (rst_i)
      (stepping && code_o == 3'b000) |=> code_o == 3'b010); // R2
   AST_STEP_S1: assert property (@(posedge clk_i) disable iff (rst_i)
      (stepping && code_o == 3'b010) |=> code_o == 3'b011); // R2
   AST_STEP_S2: assert property (@(posedge clk_i) disable iff (rst_i)
      (stepping && code_o == 3'b011) |=> code_o == 3'b101); // R2
   AST_STEP_S3: assert property (@(posedge clk_i) disable iff (rst_i)
      (stepping && code_o == 3'b101) |=> code_o == 3'b110); // R2
   AST_STEP_S4: assert property (@(posedge clk_i) disable iff (rst_i)
      (stepping && code_o == 3'b110) |=> code_o == 3'b000); // R2

   AST_RECOVER_001: assert property (@(posedge clk_i) disable iff (rst_i)
      (stepping && code_o == 3'b001) |=> code_o == 3'b110); // R3
   AST_RECOVER_100: assert property (@(posedge clk_i) disable iff (rst_i)
      (stepping && code_o == 3'b100) |=> code_o == 3'b010); // R4
   AST_RECOVER_111: assert property (@(posedge clk_i) disable iff (rst_i)
      (stepping && code_o == 3'b111) |=> code_o == 3'b100); // R5

   AST_HOLD_LOW_EN: assert property (@(posedge clk_i) disable iff (rst_i)
      (!en_i && !tst_load_i) |=> $stable(code_o)); // R7

   AST_LOAD_WRITES: assert property (@(posedge clk_i) disable iff (rst_i)
      tst_load_i |=> code_o == $past(tst_code_i)); // R8

endmodule

bind seqc_counter seqc_counter_chk i_chk (
   .clk_i      (clk_i),
   .rst_i      (rst_i),
   .en_i       (en_i),
   .tst_load_i (tst_load_i),
   .tst_code_i (tst_code_i),
   .code_o     (code_o)
);

// File: tb/test_seqc_counter.sv
module test_seqc_counter;

   localparam time TCK = 8ns;

   logic       clk_i = 1'b0;
   logic       rst_i = 1'b1;
   logic       en_i = 1'b0;
   logic       tst_load_i = 1'b0;
   logic [2:0] tst_code_i = 3'b000;
   logic [2:0] code_o;

   int n_vec  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(TCK / 2) clk_i = ~clk_i;

   seqc_counter i_seqc_counter (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .en_i       (en_i),
      .tst_load_i (tst_load_i),
      .tst_code_i (tst_code_i),
      .code_o     (code_o)
   );

   // vector: {start code, enable, expected code after one edge}
   localparam int NV = 16;
   localparam logic [6:0] VEC [NV] = '{
      {3'b000, 1'b1, 3'b010},   // R2
      {3'b010, 1'b1, 3'b011},   // R2
      {3'b011, 1'b1, 3'b101},   // R2
      {3'b101, 1'b1, 3'b110},   // R2
      {3'b110, 1'b1, 3'b000},   // R2
      {3'b001, 1'b1, 3'b110},   // R3
      {3'b100, 1'b1, 3'b010},   // R4
      {3'b111, 1'b1, 3'b100},   // R5
      {3'b000, 1'b0, 3'b000},   // R7
      {3'b010, 1'b0, 3'b010},   // R7
      {3'b011, 1'b0, 3'b011},   // R7
      {3'b101, 1'b0, 3'b101},   // R7
      {3'b110, 1'b0, 3'b110},   // R7
      {3'b001, 1'b0, 3'b001},   // R7
      {3'b100, 1'b0, 3'b100},   // R7
      {3'b111, 1'b0, 3'b111}    // R7
   };

   function automatic bit is_legal(input logic [2:0] c);
      return c == 3'b000 || c == 3'b010 || c == 3'b011 || c == 3'b101 || c == 3'b110;
   endfunction

   task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: code_o=%b expected %b", req, act, exp);
      end
   endtask

   task automatic check_legal(input string req, input logic [2:0] act);
      n_vec++;
      if (!is_legal(act)) begin
         n_fail++;
         $display("FAIL %s: code_o=%b expected a legal code", req, act);
      end
   endtask

   initial begin
      // reset state, R1
      repeat (2) @(negedge clk_i);
      check("R1", code_o, 3'b000);
      rst_i = 1'b0;

      // table walk: load start code, then one edge with the given enable
      for (int k = 0; k < NV; k++) begin
         tst_load_i = 1'b1;
         tst_code_i = VEC[k][6:4];
         en_i       = ~VEC[k][3];          // load must override enable, R8
         @(negedge clk_i);
         check("R8", code_o, VEC[k][6:4]);
         tst_load_i = 1'b0;
         en_i       = VEC[k][3];
         @(negedge clk_i);
         check(VEC[k][3] ? "R2-step" : "R7", code_o, VEC[k][2:0]);
         if (VEC[k][3]) begin
            @(negedge clk_i);
            check_legal("R6", code_o);
         end
      end

      // full legal cycle from reset, R2
      rst_i = 1'b1;
      en_i  = 1'b1;
      @(negedge clk_i);
      check("R1", code_o, 3'b000);
      rst_i = 1'b0;
      for (int k = 0; k < 10; k++) begin
         @(negedge clk_i);
         case (k % 5)
            0: check("R2", code_o, 3'b010);
            1: check("R2", code_o, 3'b011);
            2: check("R2", code_o, 3'b101);
            3: check("R2", code_o, 3'b110);
            default: check("R2", code_o, 3'b000);
         endcase
      end

      // hold for several edges mid-cycle, R7
      @(negedge clk_i);                     // now 010
      en_i = 1'b0;
      repeat (4) @(negedge clk_i);
      check("R7", code_o, 3'b010);
      en_i = 1'b1;
      @(negedge clk_i);
      check("R2", code_o, 3'b011);

      // reset wins over a pending load, R9
      rst_i      = 1'b1;
      tst_load_i = 1'b1;
      tst_code_i = 3'b111;
      @(negedge clk_i);
      check("R9", code_o, 3'b000);
      rst_i = 1'b0;
      @(negedge clk_i);
      check("R8", code_o, 3'b111);
      tst_load_i = 1'b0;
      @(negedge clk_i);
      check("R5", code_o, 3'b100);
      @(negedge clk_i);
      check("R4", code_o, 3'b010);

      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

   initial begin
      #(TCK * 200000);
      if (!done) begin
         done = 1'b1;
         n_vec++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

endmodule